// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor that fetches, decodes and completes one 32-bit instruction in every clock cycle. It supports seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch on equal and an absolute jump. Inside it are a program counter, a 32-entry register file with two read ports and one write port, an immediate extender, a three-function ALU with a zero flag, and a combinational decoder that reads the opcode and function fields.

Instruction memory and data memory are small internal arrays that hold whole words. A debug port lets a test environment fill instruction memory and data memory while reset is held. The same port reads any data word or register at any time.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and every register reads as 0. Reset is asynchronous and active low.
- R2: Field layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and immediate [15:0]. Opcode 000000 with function 100000 writes rs+rt to rd. Opcode 000000 with function 100010 writes rs-rt to rd. Any instruction that is neither a branch nor a jump advances the PC by 4.
- R3: Opcode 001101 writes rs OR the zero-extended immediate to rt.
- R4: Opcode 100011 loads a word into rt from byte address rs + sign-extended immediate. The data word index is address bits [DAW+1:2].
- R5: Opcode 101011 stores rt to byte address rs + sign-extended immediate, and writes no register.
- R6: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. If they differ, the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {PC+4 bits [31:28], instruction bits [25:0], 2'b00}. The instruction word index is PC bits [IAW+1:2].
- R8: Register 0 always reads as 0. Writes to register 0 are dropped.
- R9: An undefined opcode, or an R-type instruction with any function other than add or sub, writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_imem_we_i | input | 1 | Debug write strobe for instruction memory |
| dbg_dmem_we_i | input | 1 | Debug write strobe for data memory |
| dbg_addr_i | input | DBG_AW | Debug word index |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_dmem_rdata_o | output | 32 | Data memory word at the debug index |
| dbg_reg_addr_i | input | 5 | Debug register index |
| dbg_reg_rdata_o | output | 32 | Register value at the debug register index |
| pc_o | output | 32 | Current program counter |

## Verification
The bench builds the core with IMEM_DEPTH=32 and DMEM_DEPTH=16. With these sizes, every data word and every register can be compared with the reference model after each program, and the programs still fit with room to spare. The shallow data memory keeps the word index at 4 bits, so a negative load offset (base 16 with offset -4) is exercised with a real subtraction instead of an aligned constant. Two programs cover the following: arithmetic; a branch that is taken and one that is not; a self-loop on a branch; a jump over dead code; a write to register 0; undefined encodings that carry register fields.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned NREG = 32;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'b00,
    NPC_BR  = 2'b01,
    NPC_JMP = 2'b10
  } npc_sel_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     ld_sel;
    logic     rf_we;
    logic     dm_we;
    logic     sext;
    npc_sel_e npc;
    alu_op_e  alu;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output ctrl_t      ctl_o
);
  always_comb begin
    // default is a no-op that falls through to PC+4
    ctl_o = '{dst_rd: 1'b0, src_imm: 1'b0, ld_sel: 1'b0, rf_we: 1'b0,
              dm_we: 1'b0, sext: 1'b0, npc: NPC_SEQ, alu: ALU_ADD};
    unique case (op_i)
      OP_RTYPE: begin
        if (fn_i == FN_ADD || fn_i == FN_SUB) begin
          ctl_o.dst_rd = 1'b1;
          ctl_o.rf_we  = 1'b1;
          ctl_o.alu    = (fn_i == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.rf_we   = 1'b1;
        ctl_o.alu     = ALU_OR;
      end
      OP_LW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.sext    = 1'b1;
        ctl_o.ld_sel  = 1'b1;
        ctl_o.rf_we   = 1'b1;
      end
      OP_SW: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.sext    = 1'b1;
        ctl_o.dm_we   = 1'b1;
      end
      OP_BEQ: begin
        ctl_o.alu = ALU_SUB;
        ctl_o.npc = NPC_BR;
      end
      OP_J: ctl_o.npc = NPC_JMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] wa_i,
  input  logic [W-1:0]   wd_i,
  input  logic [RAW-1:0] ra_a_i,
  input  logic [RAW-1:0] ra_b_i,
  input  logic [RAW-1:0] ra_d_i,
  output logic [W-1:0]   rd_a_o,
  output logic [W-1:0]   rd_b_o,
  output logic [W-1:0]   rd_d_o
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_flop
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= '0;
        else if (we_i && wa_i == RAW'(g))     q <= wd_i;
      end
      assign regs[g] = q;
    end
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
  assign rd_d_o = regs[ra_d_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned DMEM_DEPTH = 64,
  localparam int unsigned IAW    = $clog2(IMEM_DEPTH),
  localparam int unsigned DAW    = $clog2(DMEM_DEPTH),
  localparam int unsigned DBG_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_imem_we_i,
  input  logic              dbg_dmem_we_i,
  input  logic [DBG_AW-1:0] dbg_addr_i,
  input  logic [31:0]       dbg_wdata_i,
  output logic [31:0]       dbg_dmem_rdata_o,
  input  logic [4:0]        dbg_reg_addr_i,
  output logic [31:0]       dbg_reg_rdata_o,
  output logic [31:0]       pc_o
);
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  logic [XLEN-1:0] pc_q, pc_nxt, pc_plus4, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, imm_ext, br_off;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wd;
  logic [4:0]      wa;
  logic            alu_zero, rf_we, dm_we;
  ctrl_t           ctl;

  assign instr = imem[pc_q[IAW+1:2]];

  sc_ctrl u_ctrl (
    .op_i  (instr[31:26]),
    .fn_i  (instr[5:0]),
    .ctl_o (ctl)
  );

  assign rf_we = ctl.rf_we & rst_ni;
  assign dm_we = ctl.dm_we & rst_ni;
  assign wa    = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .wa_i   (wa),
    .wd_i   (wd),
    .ra_a_i (instr[25:21]),
    .ra_b_i (instr[20:16]),
    .ra_d_i (dbg_reg_addr_i),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .rd_d_o (dbg_reg_rdata_o)
  );

  assign imm_ext = ctl.sext ? {{16{instr[15]}}, instr[15:0]} : {16'b0, instr[15:0]};
  assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctl.alu),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign dm_rdata = dmem[alu_y[DAW+1:2]];
  assign wd       = ctl.ld_sel ? dm_rdata : alu_y;

  // branch offset is always sign-extended, independent of ctl.sext
  assign br_off   = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + br_off;
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    unique case (ctl.npc)
      NPC_BR:  pc_nxt = alu_zero ? br_tgt : pc_plus4;
      NPC_JMP: pc_nxt = j_tgt;
      default: pc_nxt = pc_plus4;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  always_ff @(posedge clk_i) begin
    if (dbg_imem_we_i) imem[dbg_addr_i[IAW-1:0]] <= dbg_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (dbg_dmem_we_i)  dmem[dbg_addr_i[DAW-1:0]] <= dbg_wdata_i;
    else if (dm_we)     dmem[alu_y[DAW+1:2]]      <= rt_val;
  end

  assign dbg_dmem_rdata_o = dmem[dbg_addr_i[DAW-1:0]];
  assign pc_o             = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we,
  input logic        dm_we,
  input logic [4:0]  dbg_reg_addr,
  input logic [31:0] dbg_reg_rdata
);
  logic [5:0]  op, fn;
  logic        is_beq, is_j, undef;
  logic [31:0] seq_exp, br_exp, j_exp;

  assign op      = instr[31:26];
  assign fn      = instr[5:0];
  assign is_beq  = (op == OP_BEQ);
  assign is_j    = (op == OP_J);
  assign undef   = !(op inside {OP_RTYPE, OP_ORI, OP_LW, OP_SW, OP_BEQ, OP_J}) ||
                   (op == OP_RTYPE && !(fn inside {FN_ADD, FN_SUB}));
  assign seq_exp = pc + 32'd4;
  assign br_exp  = seq_exp + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign j_exp   = {seq_exp[31:28], instr[25:0], 2'b00};

  always @(posedge clk_i) begin
    if (!rst_ni) AST_PC_RESET: assert (pc == 32'd0); // R1
  end

  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_beq && !is_j) |=> pc == $past(seq_exp)); // R2
  AST_BR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && rs_val == rt_val) |=> pc == $past(br_exp)); // R6
  AST_BR_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && rs_val != rt_val) |=> pc == $past(seq_exp)); // R6
  AST_J_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_j |=> pc == $past(j_exp)); // R7
  AST_SW_NO_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (!rf_we && dm_we)); // R5
  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_reg_addr == 5'd0) |-> (dbg_reg_rdata == 32'd0)); // R8
  AST_UNDEF_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef |-> (!rf_we && !dm_we)); // R9
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pc            (pc_q),
  .instr         (instr),
  .rs_val        (rs_val),
  .rt_val        (rt_val),
  .rf_we         (rf_we),
  .dm_we         (dm_we),
  .dbg_reg_addr  (dbg_reg_addr_i),
  .dbg_reg_rdata (dbg_reg_rdata_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned IMEM       = 32;
  localparam int unsigned DMEM       = 16;
  localparam int unsigned DBG_AW     = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              dbg_imem_we_i = 1'b0;
  logic              dbg_dmem_we_i = 1'b0;
  logic [DBG_AW-1:0] dbg_addr_i = '0;
  logic [31:0]       dbg_wdata_i = '0;
  logic [31:0]       dbg_dmem_rdata_o;
  logic [4:0]        dbg_reg_addr_i = '0;
  logic [31:0]       dbg_reg_rdata_o;
  logic [31:0]       pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_im [IMEM];
  logic [31:0] m_dm [DMEM];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_core #(.IMEM_DEPTH(IMEM), .DMEM_DEPTH(DMEM)) u_dut (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .dbg_imem_we_i    (dbg_imem_we_i),
    .dbg_dmem_we_i    (dbg_dmem_we_i),
    .dbg_addr_i       (dbg_addr_i),
    .dbg_wdata_i      (dbg_wdata_i),
    .dbg_dmem_rdata_o (dbg_dmem_rdata_o),
    .dbg_reg_addr_i   (dbg_reg_addr_i),
    .dbg_reg_rdata_o  (dbg_reg_rdata_o),
    .pc_o             (pc_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(int a, output logic [31:0] v);
    dbg_reg_addr_i = 5'(a);
    #1 v = dbg_reg_rdata_o;
  endtask

  task automatic rd_mem(int a, output logic [31:0] v);
    dbg_addr_i = DBG_AW'(a);
    #1 v = dbg_dmem_rdata_o;
  endtask

  task automatic model_wr(logic [4:0] a, logic [31:0] v);
    if (a != 0) m_rf[a] = v;
  endtask

  // behavioural reference: one instruction per call
  task automatic model_step(output string tag);
    logic [31:0] ins, a, b, sx, npc, adr;
    ins = m_im[(m_pc >> 2) % IMEM];
    a   = m_rf[ins[25:21]];
    b   = m_rf[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 4;
    adr = a + sx;
    tag = "R2";
    case (ins[31:26])
      6'h00: begin
        if (ins[5:0] == 6'h20)      model_wr(ins[15:11], a + b);
        else if (ins[5:0] == 6'h22) model_wr(ins[15:11], a - b);
        else                        tag = "R9";
      end
      6'h0d: begin model_wr(ins[20:16], a | {16'h0, ins[15:0]}); tag = "R3"; end
      6'h23: begin model_wr(ins[20:16], m_dm[(adr >> 2) % DMEM]); tag = "R4"; end
      6'h2b: begin m_dm[(adr >> 2) % DMEM] = b; tag = "R5"; end
      6'h04: begin if (a == b) npc = npc + (sx << 2); tag = "R6"; end
      6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R7"; end
      default: tag = "R9";
    endcase
    m_pc = npc;
  endtask

  // reset, load both memories through the debug port, then run and compare each clock
  task automatic run_prog(int ncyc);
    logic [31:0] v;
    string tag;
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < IMEM; i++) begin
      dbg_imem_we_i = 1'b1; dbg_addr_i = DBG_AW'(i); dbg_wdata_i = m_im[i];
      @(negedge clk_i);
    end
    dbg_imem_we_i = 1'b0;
    for (int i = 0; i < DMEM; i++) begin
      dbg_dmem_we_i = 1'b1; dbg_addr_i = DBG_AW'(i); dbg_wdata_i = m_dm[i];
      @(negedge clk_i);
    end
    dbg_dmem_we_i = 1'b0;
    chk("R1 pc in reset", pc_o, 32'd0);
    rd_reg(3, v);
    chk("R1 reg in reset", v, 32'd0);
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0;
    rst_ni = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      chk("R2 pc step", pc_o, m_pc);
      model_step(tag);
      @(negedge clk_i);
      chk({tag, " pc after instr"}, pc_o, m_pc);
    end
    for (int i = 0; i < 32; i++) begin
      rd_reg(i, v);
      chk((i == 0) ? "R8 reg file" : "R2 reg file", v, m_rf[i]);
    end
    for (int i = 0; i < DMEM; i++) begin
      rd_mem(i, v);
      chk("R5 data mem", v, m_dm[i]);
    end
  endtask

  initial begin
    logic [31:0] v;
    #1 rst_ni = 1'b0;

    // program A: arithmetic, ori, lw/sw, r0 write, branches, self-loop
    for (int i = 0; i < IMEM; i++) m_im[i] = '0;
    for (int i = 0; i < DMEM; i++) m_dm[i] = 32'h1000_0000 + 32'(i);
    m_dm[3] = 32'hCAFE_F00D;
    m_im[0]  = enc_i(6'h0d, 0, 1, 16'h8001);
    m_im[1]  = enc_i(6'h0d, 0, 2, 16'h0005);
    m_im[2]  = enc_r(1, 2, 3, 6'h20);
    m_im[3]  = enc_r(2, 1, 4, 6'h22);
    m_im[4]  = enc_i(6'h2b, 0, 3, 16'h0008);
    m_im[5]  = enc_i(6'h23, 0, 5, 16'h0008);
    m_im[6]  = enc_i(6'h0d, 0, 6, 16'h0010);
    m_im[7]  = enc_i(6'h23, 6, 7, 16'hFFFC);
    m_im[8]  = enc_r(1, 2, 0, 6'h20);
    m_im[9]  = enc_i(6'h04, 1, 2, 16'h0005);
    m_im[10] = enc_i(6'h04, 2, 2, 16'h0002);
    m_im[11] = enc_i(6'h0d, 0, 8, 16'hDEAD);
    m_im[12] = enc_i(6'h0d, 0, 8, 16'hBEEF);
    m_im[13] = enc_r(5, 3, 9, 6'h22);
    m_im[14] = enc_i(6'h04, 0, 0, 16'hFFFF);
    run_prog(20);
    rd_reg(1, v); chk("R3 ori zero-extends", v, 32'h0000_8001);
    rd_reg(4, v); chk("R2 sub result", v, 32'hFFFF_8004);
    rd_reg(5, v); chk("R4 lw after sw", v, 32'h0000_8006);
    rd_reg(7, v); chk("R4 lw negative offset", v, 32'hCAFE_F00D);
    rd_reg(0, v); chk("R8 r0 write dropped", v, 32'h0);
    rd_reg(8, v); chk("R6 taken branch skips", v, 32'h0);
    rd_mem(2, v); chk("R5 sw stored rt", v, 32'h0000_8006);
    chk("R6 self-loop pc", pc_o, 32'd56);

    // program B: undefined encodings and a jump over dead code
    for (int i = 0; i < IMEM; i++) m_im[i] = '0;
    for (int i = 0; i < DMEM; i++) m_dm[i] = '0;
    m_im[0] = enc_i(6'h0d, 0, 1, 16'h1234);
    m_im[1] = enc_i(6'h3f, 0, 1, 16'hFFFF);
    m_im[2] = enc_r(1, 1, 1, 6'h25);
    m_im[3] = enc_j(26'd6);
    m_im[4] = enc_i(6'h0d, 0, 2, 16'h0007);
    m_im[5] = enc_i(6'h0d, 0, 2, 16'h0009);
    m_im[6] = enc_i(6'h2b, 0, 1, 16'h0000);
    m_im[7] = enc_j(26'd7);
    run_prog(12);
    rd_reg(1, v); chk("R9 undefined ops leave rt/rd", v, 32'h0000_1234);
    rd_reg(2, v); chk("R7 jump skips dead code", v, 32'h0);
    rd_mem(0, v); chk("R5 sw after jump", v, 32'h0000_1234);
    chk("R7 jump self-loop pc", pc_o, 32'd28);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule